// File: doc/BRIEF.md
# Port B status/control register with NMI gating

This block provides the system-control port of a PC/AT-style board. An 8-bit I/O write to the control port sets the speaker data and timer 2 gate outputs and two active-low enables for the error sources. A read of the same port returns those four bits together with four status bits. The status bits are two sticky error flags (memory parity and I/O channel check), the live timer 2 output, and a refresh-detect bit that toggles on every refresh request.

A separate write port carries the NMI mask in its data bit 7. The NMI output rises whenever NMI is unmasked and either error flag is set. Writes take effect when the active-low write strobe is released, not when it is asserted. A two-state machine follows the strobe. `WR_IDLE` moves to `WR_HELD` when the strobe is sampled low, and address and data are captured on every cycle spent in `WR_HELD`. The transition from `WR_HELD` back to `WR_IDLE` happens on the first cycle the strobe is sampled high. That transition issues a one-cycle commit that applies the captured write.

Top module: `portb_nmi_ctl`

## Requirements
- R1: After reset, NMI is masked, both error flags are clear, control bits 3..0 read 0, and the `nmi`, `spkr_data` and `tmr2_gate` outputs are low.
- R2: A write to the control port (default 061h) stores data bits 3..0. Data bits 7..4 of that write have no effect. `tmr2_gate` follows bit 0 and `spkr_data` follows bit 1.
- R3: A read of the control port returns bit 7 = parity flag, bit 6 = I/O check flag, bit 5 = `tmr2_out`, bit 4 = refresh toggle, and bits 3..0 = stored control bits.
- R4: While control bit 2 is 0, a cycle with `parity_err` high sets the parity flag. The flag stays set after `parity_err` falls.
- R5: While control bit 3 is 0, a cycle with `iochk_err` high sets the I/O check flag. The flag stays set after `iochk_err` falls.
- R6: While control bit 2 (or bit 3) is 1, the matching flag is cleared one cycle after the bit is stored and stays clear whatever the error input does.
- R7: The refresh toggle bit inverts on every clock cycle in which `refresh_req` is high, and holds otherwise.
- R8: A write to the mask port (default 070h) with data bit 7 = 0 unmasks NMI. With data bit 7 = 1 it masks NMI.
- R9: `nmi` is high exactly when NMI is unmasked and at least one error flag is set.
- R10: A write takes effect on the clock edge where the released strobe is first sampled high. While the strobe is held low, the outputs keep their old values.
- R11: Writes to any other address change nothing. `io_rdata` is 0 unless a read of the control port is in progress, including reads of the mask port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W (10) | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr_n | input | 1 | Active-low write strobe |
| io_rd | input | 1 | Read enable |
| io_rdata | output | 8 | Read data, 0 when not selected |
| parity_err | input | 1 | Memory parity error indication |
| iochk_err | input | 1 | I/O channel check indication |
| tmr2_out | input | 1 | Timer 2 output, reported in status |
| refresh_req | input | 1 | One pulse per refresh request |
| spkr_data | output | 1 | Speaker data enable |
| tmr2_gate | output | 1 | Timer 2 gate |
| nmi | output | 1 | Non-maskable interrupt request |

## Verification
Random sequences mix control-port writes, mask writes, writes to stray addresses, one-cycle error pulses and refresh pulses. A reference model then checks the read-back byte, the two control outputs and `nmi` after every operation. Error pulses that arrive while the enable bit is 1 show that gating differs from plain latching. Mask-port writes alternate bit 7 so that the unmask and mask effects can be told apart from flag changes. Directed cases cover:
- Holding the strobe low over several edges, to show that the commit waits for release.
- Upper-nibble data on the control port, to show those bits are ignored.
- A read of the mask port, which must return 0.

// File: rtl/portb_nmi_pkg.sv
package portb_nmi_pkg;
    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_HELD = 1'b1
    } wr_state_t;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CTRL_W = 4;
    localparam int unsigned NUM_SRC = 2;   // 0: parity, 1: I/O check
endpackage

// File: rtl/portb_wr_fsm.sv
module portb_wr_fsm
    import portb_nmi_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              commit,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [BYTE_W-1:0] cap_data
);
    wr_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: if (!wr_n) state_d = WR_HELD;
            WR_HELD: if (wr_n)  state_d = WR_IDLE;
            default: state_d = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
        end else if (!wr_n) begin
            cap_addr <= addr;
            cap_data <= wdata;
        end
    end

    always_comb begin
        commit = 1'b0;
        unique case (state_q)
            WR_IDLE: commit = 1'b0;
            WR_HELD: commit = wr_n;
            default: commit = 1'b0;
        endcase
    end
endmodule

// File: rtl/portb_err_latch.sv
module portb_err_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic err_in,
    input  logic block_n_en,  // 1 = source disabled and flag held clear
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n)          flag <= 1'b0;
        else if (block_n_en) flag <= 1'b0;
        else if (err_in)     flag <= 1'b1;
    end
endmodule

// File: rtl/portb_nmi_ctl.sv
module portb_nmi_ctl
    import portb_nmi_pkg::*;
#(
    parameter int unsigned ADDR_W     = 10,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 10'h061,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 10'h070
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_wr_n,
    input  logic              io_rd,
    output logic [7:0]        io_rdata,
    input  logic              parity_err,
    input  logic              iochk_err,
    input  logic              tmr2_out,
    input  logic              refresh_req,
    output logic              spkr_data,
    output logic              tmr2_gate,
    output logic              nmi
);
    logic              commit;
    logic [ADDR_W-1:0] cap_addr;
    logic [BYTE_W-1:0] cap_data;
    logic [CTRL_W-1:0] ctrl_q;
    logic              nmi_en_q;
    logic              ref_tog_q;
    logic [NUM_SRC-1:0] err_vec, flag_vec;

    portb_wr_fsm #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_n(io_wr_n), .addr(io_addr),
        .wdata(io_wdata), .commit(commit), .cap_addr(cap_addr),
        .cap_data(cap_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            nmi_en_q <= 1'b0;
        end else if (commit) begin
            if (cap_addr == CTRL_ADDR) ctrl_q   <= cap_data[CTRL_W-1:0];
            if (cap_addr == MASK_ADDR) nmi_en_q <= ~cap_data[7];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           ref_tog_q <= 1'b0;
        else if (refresh_req) ref_tog_q <= ~ref_tog_q;
    end

    assign err_vec = {iochk_err, parity_err};

    // Source i is gated by control bit 2+i (parity: 2, I/O check: 3).
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        portb_err_latch u_lat (
            .clk(clk), .rst_n(rst_n), .err_in(err_vec[i]),
            .block_n_en(ctrl_q[2+i]), .flag(flag_vec[i])
        );
    end

    assign io_rdata  = (io_rd && io_addr == CTRL_ADDR)
                     ? {flag_vec[0], flag_vec[1], tmr2_out, ref_tog_q, ctrl_q}
                     : '0;
    assign spkr_data = ctrl_q[1];
    assign tmr2_gate = ctrl_q[0];
    assign nmi       = nmi_en_q & (|flag_vec);
endmodule

// File: rtl/portb_nmi_chk.sv
module portb_nmi_chk #(
    parameter int unsigned ADDR_W = 10,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 10'h070
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nmi,
    input logic              nmi_en,
    input logic [1:0]        flags,
    input logic [3:0]        ctrl,
    input logic              refresh_req,
    input logic              ref_tog,
    input logic              commit,
    input logic [ADDR_W-1:0] cap_addr,
    input logic [7:0]        cap_data,
    input logic              io_wr_n
);
    // R9
    nmi_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |-> (nmi_en && flags != 2'b00));
    // R6
    par_held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[2] |=> !flags[0]);
    // R6
    chk_held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[3] |=> !flags[1]);
    // R4
    par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !ctrl[2]) |=> flags[0]);
    // R7
    ref_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |=> (ref_tog != $past(ref_tog)));
    // R7
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh_req |=> $stable(ref_tog));
    // R8
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cap_addr == MASK_ADDR) |=> (nmi_en == !$past(cap_data[7])));
    // R10
    no_commit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> io_wr_n);
endmodule

bind portb_nmi_ctl portb_nmi_chk #(.ADDR_W(ADDR_W), .MASK_ADDR(MASK_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .nmi(nmi), .nmi_en(nmi_en_q), .flags(flag_vec),
    .ctrl(ctrl_q), .refresh_req(refresh_req), .ref_tog(ref_tog_q),
    .commit(commit), .cap_addr(cap_addr), .cap_data(cap_data), .io_wr_n(io_wr_n)
);

// File: tb/tb_portb_nmi_ctl.sv
module tb_portb_nmi_ctl;
    localparam int CLK_NS = 20;
    logic       clk = 0, rst_n = 0;
    logic [9:0] io_addr = '0;
    logic [7:0] io_wdata = '0, io_rdata;
    logic       io_wr_n = 1, io_rd = 0;
    logic       parity_err = 0, iochk_err = 0, tmr2_out = 0, refresh_req = 0;
    logic       spkr_data, tmr2_gate, nmi;
    int total = 0, bad = 0;

    logic [3:0] m_ctrl = '0;
    logic m_par = 0, m_chk = 0, m_nen = 0, m_tog = 0;

    always #(CLK_NS/2) clk = ~clk;

    portb_nmi_ctl dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr_n(io_wr_n), .io_rd(io_rd), .io_rdata(io_rdata),
        .parity_err(parity_err), .iochk_err(iochk_err), .tmr2_out(tmr2_out),
        .refresh_req(refresh_req), .spkr_data(spkr_data),
        .tmr2_gate(tmr2_gate), .nmi(nmi)
    );

    function automatic logic [7:0] exp_byte();
        return {m_par, m_chk, tmr2_out, m_tog, m_ctrl};
    endfunction

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    task automatic rd_check(string tag);
        @(negedge clk);
        io_addr = 10'h061; io_rd = 1;
        #1;
        check({tag, " R3 read"}, io_rdata, exp_byte());
        io_rd = 0;
        check({tag, " R2 outs"}, {6'd0, spkr_data, tmr2_gate}, {6'd0, m_ctrl[1:0]});
        check({tag, " R9 nmi"}, {7'd0, nmi}, {7'd0, m_nen & (m_par | m_chk)});
    endtask

    task automatic io_write(logic [9:0] a, logic [7:0] d, int hold);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr_n = 0;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            // R10: nothing applied while strobe is still low
            check("R10 held", {6'd0, spkr_data, tmr2_gate}, {6'd0, m_ctrl[1:0]});
        end
        io_wr_n = 1; io_addr = $urandom; io_wdata = $urandom;
        @(negedge clk);
        @(negedge clk);
        if (a == 10'h061) begin
            m_ctrl = d[3:0];
            if (d[2]) m_par = 0;
            if (d[3]) m_chk = 0;
        end else if (a == 10'h070) m_nen = !d[7];
    endtask

    task automatic pulse(int which);
        @(negedge clk);
        if (which == 0) parity_err = 1;
        else if (which == 1) iochk_err = 1;
        else refresh_req = 1;
        @(negedge clk);
        parity_err = 0; iochk_err = 0; refresh_req = 0;
        if (which == 0 && !m_ctrl[2]) m_par = 1;
        if (which == 1 && !m_ctrl[3]) m_chk = 1;
        if (which == 2) m_tog = !m_tog;
    endtask

    initial begin
        #(CLK_NS * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd_check("R1");
        // R11: mask-port read is not decoded
        @(negedge clk); io_addr = 10'h070; io_rd = 1; #1;
        check("R11 mask read", io_rdata, 8'h00); io_rd = 0;
        // R2: upper nibble ignored, R10 hold over several edges
        io_write(10'h061, 8'hF3, 3); rd_check("R2 upper");
        // R4 parity latch, R5 I/O check latch with enables low
        io_write(10'h061, 8'h00, 1);
        pulse(0); rd_check("R4 par"); repeat (3) @(negedge clk); rd_check("R4 sticky");
        pulse(1); rd_check("R5 chk");
        // R8 unmask -> R9 nmi
        io_write(10'h070, 8'h00, 1); rd_check("R8 unmask");
        io_write(10'h070, 8'h80, 1); rd_check("R8 mask");
        // R6 clear and hold clear
        io_write(10'h061, 8'h0C, 1); rd_check("R6 clear");
        pulse(0); pulse(1); rd_check("R6 held");
        // R11 stray address
        io_write(10'h062, 8'h03, 1); rd_check("R11 stray");
        // R7 refresh
        pulse(2); rd_check("R7 a"); pulse(2); rd_check("R7 b");
        // random mix
        for (int i = 0; i < 300; i++) begin
            int op = $urandom_range(0, 5);
            tmr2_out = $urandom;
            case (op)
                0: io_write(10'h061, $urandom, $urandom_range(1, 3));
                1: io_write(10'h070, $urandom, 1);
                2: io_write($urandom, $urandom, 1);
                default: pulse(op - 3);
            endcase
            rd_check("rand");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule